// File: doc/BRIEF.md
# Digital Potentiometer Wiper Serial Transmitter

This block loads an 8-bit wiper setting into a digital potentiometer over a transmit-only serial link. The whole block runs from one externally supplied serial clock. That clock must not exceed 25 MHz, so a 100 MHz system clock divided by four is a typical source. During a frame the block forwards a gated copy of this clock to the serial clock pin. Between frames the pin rests low.

A user-side client presents a value and raises `update`. When the block is idle and armed, it captures the value, pulls chip select low and shifts the byte out most significant bit first. Data changes on the falling clock edge, so the potentiometer samples settled data on each rising edge. `ready` is low for the whole frame. A request that stays high starts only one frame. The block re-arms only after it has seen `update` low.

All internal state changes on the falling edge of the input clock. This keeps the clock gate glitch-free and places data changes midway between the rising edges that the device uses.

Top module: `pot_spi_tx`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a falling clock edge) returns the block to idle from any state: `cs_n` = 1, `ready` = 1, `mosi` = 0, and `sclk` stays low.
- R2: When `ready` = 1, the block is armed and `update` = 1 at a falling clock edge, a frame starts at that edge: `cs_n` falls and `ready` falls together.
- R3: Every frame carries exactly 8 rising edges on `sclk`. `sclk` never pulses while `cs_n` = 1.
- R4: The 8 bits seen on `mosi` at the 8 rising `sclk` edges equal the captured value, bit 7 first and bit 0 last.
- R5: `mosi` is 0 whenever `cs_n` = 1 after reset.
- R6: The value is captured when the frame starts. Changes on `value` during the frame do not alter the bits sent.
- R7: `update` pulses while `ready` = 0 start no frame and do not disturb the current one. If `update` is low again when the frame ends, no further frame follows.
- R8: An `update` held high starts exactly one frame. A new frame starts only after `update` has been sampled low and then high again.
- R9: `cs_n` rises at the falling edge that ends the 8th pulse, and `ready` equals `cs_n` at all times.
- R10: A request that is high when a frame ends starts the next frame one clock period after `cs_n` rises, provided `update` was sampled low at some edge since the previous frame started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from outside (at most 25 MHz); it also clocks all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| value | input | 8 | Wiper setting to send |
| update | input | 1 | Request to send `value` |
| ready | output | 1 | High when no frame is in progress |
| cs_n | output | 1 | Active-low chip select, low for one frame |
| sclk | output | 1 | Gated copy of `clk`, low when idle |
| mosi | output | 1 | Serial data, most significant bit first |

## Verification
The bench sends the all-zeros, all-ones, single-top-bit, single-bottom-bit and alternating bytes. These separate bit order, stuck data and off-by-one shifting. Random bytes then follow, with random idle gaps and random changes to `value` during each frame; these show whether the byte is really captured at the start. Directed sequences separate the three request patterns: a pulse while busy that must be ignored, a held request that must start only one frame, and a request that re-arms during a frame and so must start the next frame after a one-cycle gap. A reset applied mid-frame must return the block to idle at once.

// File: rtl/pot_spi_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the potentiometer serial transmitter.
// Assumes: a single clock domain. The sequencer state is a two-value enum.
package pot_spi_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_t;

endpackage

// File: rtl/pot_req_arm.sv
`timescale 1ns/1ps
// Module: pot_req_arm
// Turns the level-sensitive update request into a single start strobe.
// A start clears the armed flag. Seeing update low sets it again, so a
// held request launches only one frame.
// Assumes: updates on the falling clock edge, like the rest of the block.
module pot_req_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic update,
    input  logic idle,
    output logic start
);

    logic armed_q;

    // Purpose: accept a request only when idle and armed.
    assign start = update & armed_q & idle;

    // Purpose: track whether update has been low since the last start.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (start) begin
            armed_q <= 1'b0;
        end else if (!update) begin
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pot_frame_seq.sv
`timescale 1ns/1ps
// Module: pot_frame_seq
// Frame sequencer. It counts DATA_W bit periods and drives chip select,
// the clock-gate enable and the shift and finish strobes for the datapath.
// Assumes: state moves on the falling edge, so the enable changes only
// while the clock is low.
module pot_frame_seq
    import pot_spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic cs_n,
    output logic sclk_en,
    output logic shift,
    output logic finish
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             at_last;

    // Purpose: decode the last bit period and the strobes for the datapath.
    always_comb begin
        at_last = (bit_cnt_q == LAST_BIT);
        idle    = (state_q == SEQ_IDLE);
        shift   = (state_q == SEQ_SHIFT) && !at_last;
        finish  = (state_q == SEQ_SHIFT) && at_last;
    end

    // Purpose: advance the frame state and the bit counter.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            bit_cnt_q <= '0;
        end else if (start) begin
            state_q   <= SEQ_SHIFT;
            bit_cnt_q <= '0;
        end else if (finish) begin
            state_q   <= SEQ_IDLE;
            bit_cnt_q <= '0;
        end else if (shift) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Purpose: register chip select and the clock-gate enable.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sclk_en <= 1'b0;
        end else if (start) begin
            cs_n    <= 1'b0;
            sclk_en <= 1'b1;
        end else if (finish) begin
            cs_n    <= 1'b1;
            sclk_en <= 1'b0;
        end
    end

endmodule

// File: rtl/pot_shifter.sv
`timescale 1ns/1ps
// Module: pot_shifter
// Captures the wiper value at frame start and presents it on the data
// pin MSB first, one bit per falling edge. Data rests low when idle.
// Assumes: load, shift and finish strobes are mutually exclusive.
module pot_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              finish,
    input  logic [DATA_W-1:0] din,
    output logic              mosi
);

    logic [DATA_W-1:0] sreg_q;

    // Purpose: hold the remaining bits and drive the current bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            mosi   <= 1'b0;
        end else if (load) begin
            mosi   <= din[DATA_W-1];
            sreg_q <= din << 1;
        end else if (shift) begin
            mosi   <= sreg_q[DATA_W-1];
            sreg_q <= sreg_q << 1;
        end else if (finish) begin
            mosi   <= 1'b0;
        end
    end

endmodule

// File: rtl/pot_sclk_gate.sv
`timescale 1ns/1ps
// Module: pot_sclk_gate
// Forwards the input clock to the serial clock pin while enabled.
// Assumes: the enable changes only while clk is low, so the output
// has no runt pulses. The pin rests low.
module pot_sclk_gate (
    input  logic clk,
    input  logic en,
    output logic sclk
);

    // Purpose: AND-gate the clock with a low-phase-stable enable.
    assign sclk = clk & en;

endmodule

// File: rtl/pot_spi_tx.sv
`timescale 1ns/1ps
// Module: pot_spi_tx (top)
// Transmit-only serial link that loads a wiper setting into a digital
// potentiometer. It connects the request arming logic, the frame
// sequencer, the data shifter and the clock gate.
// Assumes: clk is the serial clock itself (at most 25 MHz), and reset is
// synchronous and active low.
module pot_spi_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] value,
    input  logic              update,
    output logic              ready,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi
);

    logic start;
    logic idle;
    logic sclk_en;
    logic shift;
    logic finish;

    // Purpose: ready mirrors the sequencer's idle state.
    assign ready = idle;

    pot_req_arm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (update),
        .idle   (idle),
        .start  (start)
    );

    pot_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .idle    (idle),
        .cs_n    (cs_n),
        .sclk_en (sclk_en),
        .shift   (shift),
        .finish  (finish)
    );

    pot_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .shift  (shift),
        .finish (finish),
        .din    (value),
        .mosi   (mosi)
    );

    pot_sclk_gate u_gate (
        .clk  (clk),
        .en   (sclk_en),
        .sclk (sclk)
    );

endmodule

// File: rtl/pot_spi_tx_chk.sv
`timescale 1ns/1ps
// Module: pot_spi_tx_chk
// Assertion checker bound to pot_spi_tx. It samples on the rising edge,
// midway between the falling edges where the design's state changes.
// Assumes: the update input is steady from a falling edge to the next
// rising edge.
module pot_spi_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic update,
    input logic ready,
    input logic cs_n,
    input logic sclk_en
);

    localparam int PC_W = $clog2(DATA_W + 1) + 1;

    logic [PC_W-1:0] pulse_cnt_q;

    // Purpose: count clock pulses forwarded within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            pulse_cnt_q <= '0;
        end else if (sclk_en) begin
            pulse_cnt_q <= pulse_cnt_q + 1'b1;
        end
    end

    // R9: ready and chip select always agree
    p_ready_tracks_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready == cs_n);

    // R3: no clock pulses while deselected
    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk_en);

    // R3: a frame never exceeds its pulse budget
    p_no_extra_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt_q <= PC_W'(DATA_W));

    // R3: each frame closes after exactly DATA_W pulses
    p_frame_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (pulse_cnt_q == PC_W'(DATA_W)));

    // R2: a frame starts only on a request
    p_start_on_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> update);

endmodule

bind pot_spi_tx pot_spi_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .update  (update),
    .ready   (ready),
    .cs_n    (cs_n),
    .sclk_en (sclk_en)
);

// File: tb/tb_pot_spi_tx.sv
`timescale 1ns/1ps
// Bench for pot_spi_tx: a serial receiver model plus directed and seeded
// random frames.
module tb_pot_spi_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] value = 8'h00;
    logic       update = 1'b0;
    logic       ready, cs_n, sclk, mosi;

    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;
    int stray = 0;
    int rx_cnt = 0;
    logic [7:0] rx = 8'h00;

    always #4 clk = ~clk;

    pot_spi_tx dut (
        .clk(clk), .rst_n(rst_n), .value(value), .update(update),
        .ready(ready), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
    );

    // Receiver model: the device samples on the rising serial clock edge.
    always @(posedge sclk) begin
        if (cs_n) stray = stray + 1;
        else begin
            rx = {rx[6:0], mosi};
            rx_cnt = rx_cnt + 1;
        end
    end

    always @(negedge cs_n) begin
        frames = frames + 1;
        rx_cnt = 0;
    end

    function automatic logic [7:0] exp_word(input logic [7:0] v);
        // The receiver shifts left, so MSB-first delivery rebuilds v unchanged.
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drv(input logic u, input logic [7:0] v);
        @(posedge clk);
        #1;
        update = u;
        value  = v;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One frame: request, release, optionally scramble value, check.
    task automatic send(input logic [7:0] v, input bit noise);
        drv(1'b1, v);
        @(negedge cs_n);
        #1;
        check("R2 ready low in frame", int'(ready), 0);
        drv(1'b0, noise ? 8'($urandom) : v);
        if (noise) drv(1'b0, 8'($urandom));
        @(posedge cs_n);
        #1;
        check("R4/R6 received byte", int'(rx), int'(exp_word(v)));
        check("R3 pulses per frame", rx_cnt, 8);
        check("R9 ready at frame end", int'(ready), 1);
        check("R5 mosi idle low", int'(mosi), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int f0;
        realtime t0, t1;
        void'($urandom(32'h5EED));

        // R1: reset state
        repeat (4) @(posedge clk);
        #2;
        check("R1 cs_n in reset", int'(cs_n), 1);
        check("R1 ready in reset", int'(ready), 1);
        check("R1 mosi in reset", int'(mosi), 0);
        check("R1 sclk in reset", int'(sclk), 0);
        drv(1'b0, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R1 sclk idle after reset", int'(sclk), 0);

        // R4: directed patterns
        send(8'h00, 1'b0);
        send(8'hFF, 1'b0);
        send(8'h80, 1'b0);
        send(8'h01, 1'b0);
        send(8'hA5, 1'b0);
        send(8'h5A, 1'b1);

        // R7: a pulse while busy is ignored
        drv(1'b1, 8'h3C);
        @(negedge cs_n);
        drv(1'b0, 8'h3C);
        drv(1'b1, 8'hC3);
        drv(1'b0, 8'hC3);
        @(posedge cs_n);
        #1;
        check("R7 byte kept", int'(rx), 8'h3C);
        f0 = frames;
        repeat (5) @(posedge clk);
        #2;
        check("R7 no extra frame", frames, f0);
        check("R7 cs stays high", int'(cs_n), 1);

        // R8: a held request starts one frame only
        drv(1'b1, 8'h96);
        @(posedge cs_n);
        f0 = frames;
        repeat (6) @(posedge clk);
        #2;
        check("R8 held request once", frames, f0);
        check("R8 ready while held", int'(ready), 1);
        drv(1'b0, 8'h96);
        drv(1'b1, 8'h69);
        @(negedge cs_n);
        drv(1'b0, 8'h00);
        @(posedge cs_n);
        #1;
        check("R8 re-armed frame byte", int'(rx), 8'h69);

        // R10: a re-armed standing request gives a one-cycle gap
        drv(1'b1, 8'hE1);
        @(negedge cs_n);
        drv(1'b0, 8'hE1);
        drv(1'b1, 8'h1E);
        @(posedge cs_n);
        t0 = $realtime;
        #1;
        check("R10 first byte", int'(rx), 8'hE1);
        @(negedge cs_n);
        t1 = $realtime;
        check("R10 gap ns", int'(t1 - t0), 8);
        drv(1'b0, 8'h00);
        @(posedge cs_n);
        #1;
        check("R10 second byte", int'(rx), 8'h1E);

        // Seeded random frames, with gaps and value noise (R4, R6)
        for (int i = 0; i < 30; i++) begin
            repeat ($urandom_range(3, 0)) @(posedge clk);
            send(8'($urandom), 1'b1);
        end

        // R1: reset in mid-frame returns to idle
        drv(1'b1, 8'hF0);
        @(negedge cs_n);
        drv(1'b0, 8'h00);
        drv(1'b0, 8'h00);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 cs_n after mid-frame reset", int'(cs_n), 1);
        check("R1 ready after mid-frame reset", int'(ready), 1);
        check("R1 mosi after mid-frame reset", int'(mosi), 0);
        check("R1 sclk after mid-frame reset", int'(sclk), 0);
        drv(1'b0, 8'h00);
        rst_n = 1'b1;
        send(8'h42, 1'b0);

        check("R3 stray pulses while deselected", stray, 0);
        finish_run();
    end

endmodule